// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides a fast oscillator clock by a programmable integer N for the feedback path of a frequency synthesiser. A 15-bit division word is split into an 11-bit main count M (bits 14:4) and a 4-bit swallow count A (bits 3:0). A prescaler runs at modulus 17 for the first A of its output periods and at modulus 16 for the rest, and the main counter ends the output cycle after M prescaler periods in all. One output cycle therefore lasts 16·M + A input clocks.

Each output cycle ends with a single-clock pulse on the divided output, and a half-rate square wave that flips on every pulse is provided for routing to a test pin. A new division word is sampled only at the end of a cycle, so retuning never shortens or stretches a cycle already under way. A word below 240 cannot be built from this counter pair (M would fall below the largest possible A); such a word is refused, a range flag is raised, and the last accepted word stays in force.

Top module: `psw_divider`

## Requirements
- R1: For an accepted word W (M = W[14:4], A = W[3:0]), consecutive `fpd_o` pulses are exactly 16·M + A = W input clocks apart.
- R2: `fpd_o` is high for exactly one input clock per output cycle.
- R3: `fpd_half_o` inverts on every clock in which `fpd_o` is high and holds its level on every other clock.
- R4: `word_i` is sampled only in the clock that ends an output cycle; a change presented at any other time leaves the running cycle at its old length and governs the next cycle.
- R5: A word below 240 sampled at a cycle end is refused: the next cycle keeps the previously accepted length, and `range_err_o` goes high with that cycle-end pulse; it returns low at the first cycle end that samples a word of 240 or more, and changes at no other time.
- R6: While `rst_ni` is low, `fpd_o`, `fpd_half_o` and `range_err_o` are low and the accepted word is 240; the first cycle end after reset release samples `word_i`.
- R7: The largest word, 32767 (M = 2047, A = 15), gives cycles of exactly 32767 clocks.
- R8: The smallest word 240 (M = 15, A = 0, prescaler never at 17) and 255 (M = 15, A = 15, prescaler at 17 for the whole cycle) give cycles of exactly 240 and 255 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock being divided |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_i | input | 15 | Division word: M in bits 14:4, A in bits 3:0 |
| fpd_o | output | 1 | One-clock pulse ending each output cycle |
| fpd_half_o | output | 1 | Square wave at half the pulse rate, for test observation |
| range_err_o | output | 1 | High while the last sampled word was below 240 |

## Verification
The bench goes after the two extremes of the swallow count, A = 0 and A = 15 with the minimum M, where a wrong modulus hand-over shows up as a cycle one or fifteen clocks off. It changes the word well inside a long cycle: a design that loads the word at once would cut that cycle short. It presents words of 239 and 0, including during reset, where a design that accepts them would yield cycles of the wrong length or a flag that never rises, and it runs the full 32767 ratio, where an overflowing main counter would wrap to a short cycle.

// File: rtl/psw_pkg.sv
package psw_pkg;
  // Default split of the division word
  localparam int unsigned SWALLOW_W = 4;
  localparam int unsigned MAIN_W    = 11;
  localparam int unsigned RATIO_MIN = 240;
endpackage

// File: rtl/psw_rst_sync.sv
module psw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
  parameter int unsigned BASE_MOD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic long_i,   // choose BASE_MOD+1 for the period that starts after tc
  output logic tc_o
);
  localparam int unsigned CNT_W = $clog2(BASE_MOD + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tc_o = (cnt_q == '0);

  always_comb begin
    if (tc_o) cnt_d = long_i ? CNT_W'(BASE_MOD) : CNT_W'(BASE_MOD - 1);
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/psw_cycle_ctl.sv
module psw_cycle_ctl #(
  parameter int unsigned SWALLOW_W = 4,
  parameter int unsigned MAIN_W    = 11,
  parameter int unsigned RATIO_MIN = 240
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         tc_i,
  input  logic [SWALLOW_W+MAIN_W-1:0]  word_i,
  output logic                         long_o,
  output logic                         fpd_o,
  output logic                         fpd_half_o,
  output logic                         range_err_o
);
  localparam int unsigned WORD_W = SWALLOW_W + MAIN_W;

  logic [WORD_W-1:0]    held_q, held_d;
  logic [MAIN_W-1:0]    main_q, main_d;
  logic [SWALLOW_W-1:0] swal_q, swal_d;
  logic                 fpd_q, fpd_d;
  logic                 half_q, half_d;
  logic                 err_q, err_d;
  logic                 word_ok;
  logic                 cyc_end;
  logic [WORD_W-1:0]    word_sel;

  assign word_ok  = (word_i >= WORD_W'(RATIO_MIN));
  assign word_sel = word_ok ? word_i : held_q;
  assign cyc_end  = tc_i && (main_q <= MAIN_W'(1));

  always_comb begin
    held_d = held_q;
    main_d = main_q;
    swal_d = swal_q;
    fpd_d  = 1'b0;
    half_d = half_q;
    err_d  = err_q;
    if (cyc_end) begin
      held_d = word_sel;
      main_d = word_sel[WORD_W-1:SWALLOW_W];
      swal_d = word_sel[SWALLOW_W-1:0];
      fpd_d  = 1'b1;
      half_d = ~half_q;
      err_d  = ~word_ok;
    end else if (tc_i) begin
      main_d = main_q - 1'b1;
      swal_d = (swal_q != '0) ? swal_q - 1'b1 : swal_q;
    end
  end

  // the prescaler period started at this tc is long while swallows remain
  assign long_o = (swal_d != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= WORD_W'(RATIO_MIN);
      main_q <= '0;
      swal_q <= '0;
      fpd_q  <= 1'b0;
      half_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      held_q <= held_d;
      main_q <= main_d;
      swal_q <= swal_d;
      fpd_q  <= fpd_d;
      half_q <= half_d;
      err_q  <= err_d;
    end
  end

  assign fpd_o       = fpd_q;
  assign fpd_half_o  = half_q;
  assign range_err_o = err_q;
endmodule

// File: rtl/psw_divider.sv
module psw_divider
  import psw_pkg::*;
#(
  parameter int unsigned A_BITS    = SWALLOW_W,
  parameter int unsigned M_BITS    = MAIN_W,
  parameter int unsigned MIN_RATIO = RATIO_MIN
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [A_BITS+M_BITS-1:0] word_i,
  output logic                     fpd_o,
  output logic                     fpd_half_o,
  output logic                     range_err_o
);
  localparam int unsigned WORD_W   = A_BITS + M_BITS;
  localparam int unsigned PRE_BASE = 2 ** A_BITS;

  logic rst_int_n;
  logic pre_tc;
  logic pre_long;

  psw_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  psw_prescaler #(.BASE_MOD(PRE_BASE)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .long_i (pre_long),
    .tc_o   (pre_tc)
  );

  psw_cycle_ctl #(
    .SWALLOW_W (A_BITS),
    .MAIN_W    (M_BITS),
    .RATIO_MIN (MIN_RATIO)
  ) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .tc_i        (pre_tc),
    .word_i      (word_i),
    .long_o      (pre_long),
    .fpd_o       (fpd_o),
    .fpd_half_o  (fpd_half_o),
    .range_err_o (range_err_o)
  );
endmodule

// File: rtl/psw_divider_chk.sv
module psw_divider_chk #(
  parameter int unsigned WORD_W    = 15,
  parameter int unsigned MIN_RATIO = 240
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] word_i,
  input logic              fpd_o,
  input logic              fpd_half_o,
  input logic              range_err_o
);
  // R2
  fpd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fpd_o |=> !fpd_o);

  // R3
  half_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fpd_o |-> (fpd_half_o != $past(fpd_half_o)));

  // R3
  half_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fpd_o |-> $stable(fpd_half_o));

  // R5
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fpd_o |-> $stable(range_err_o));

  // R5
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fpd_o && range_err_o) |-> ($past(word_i) < WORD_W'(MIN_RATIO)));

  // R5
  err_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fpd_o && !range_err_o) |-> ($past(word_i) >= WORD_W'(MIN_RATIO)));

  // R6
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!fpd_o && !fpd_half_o && !range_err_o);
    end
  end
endmodule

bind psw_divider psw_divider_chk #(
  .WORD_W    (WORD_W),
  .MIN_RATIO (MIN_RATIO)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .word_i      (word_i),
  .fpd_o       (fpd_o),
  .fpd_half_o  (fpd_half_o),
  .range_err_o (range_err_o)
);

// File: tb/psw_divider_tb_top.sv
module psw_divider_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [14:0] word_i;
  logic        fpd_o, fpd_half_o, range_err_o;

  int checks   = 0;
  int failures = 0;
  int exp_q[$];
  int accepted = 240;
  bit done     = 0;

  always #2.5 clk_i = ~clk_i;

  psw_divider dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_i      (word_i),
    .fpd_o       (fpd_o),
    .fpd_half_o  (fpd_half_o),
    .range_err_o (range_err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk_i); while (!fpd_o);
  endtask

  // driver: one expected interval pushed per pulse, for the cycle that pulse starts
  task automatic apply(input int w, input int n, input int mid);
    wait_pulse();
    exp_q.push_back(accepted);          // R4: running cycle keeps the old word
    repeat (mid) @(negedge clk_i);
    word_i = 15'(w);
    if (w >= 240) accepted = w;
    wait_pulse();
    check("R5 range flag", int'(range_err_o), (w < 240) ? 1 : 0);
    exp_q.push_back(accepted);
    for (int k = 2; k < n; k++) begin
      wait_pulse();
      exp_q.push_back(accepted);
    end
  endtask

  // monitor: measures pulse spacing and the half-rate output
  int  gap       = 0;
  bit  started   = 0;
  bit  last_fpd  = 0;
  bit  last_half = 0;
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      gap++;
      if (fpd_o && last_fpd) check("R2 pulse width", 2, 1);
      if (fpd_o) begin
        if (started) begin
          if (exp_q.size() == 0) check("R1 unexpected pulse", gap, 0);
          else check("R1/R4 interval", gap, exp_q.pop_front());
          check("R3 half toggles", int'(fpd_half_o), int'(!last_half));
        end
        gap     = 0;
        started = 1;
        last_half = fpd_half_o;
      end else if (started && fpd_half_o != last_half) begin
        check("R3 half stable", int'(fpd_half_o), int'(last_half));
      end
      last_fpd = fpd_o;
    end
  end

  initial begin
    rst_ni = 1'b0;
    word_i = 15'd0;
    repeat (5) @(negedge clk_i);
    // R6 reset state
    check("R6 fpd in reset", int'(fpd_o), 0);
    check("R6 half in reset", int'(fpd_half_o), 0);
    check("R6 err in reset", int'(range_err_o), 0);
    rst_ni = 1'b1;
    wait_pulse();
    // R6: word 0 refused at first cycle end, reset word 240 used
    check("R6 first sample flag", int'(range_err_o), 1);
    exp_q.push_back(accepted);
    apply(1000, 3, 50);      // R1
    apply(255, 3, 10);       // R8 all-swallow
    apply(240, 2, 5);        // R8 no swallow
    apply(239, 3, 7);        // R5
    apply(4097, 2, 100);     // R1
    apply(32767, 3, 3000);   // R7
    apply(500, 2, 20000);    // R4 change deep inside a long cycle
    wait_pulse();
    @(negedge clk_i);
    check("R1 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule